// File: doc/BRIEF.md
# Receive FIFO with Accumulated Error Status

This block stores received characters on their way from a serial receiver to a host. Each entry holds a character and three error flags, and the block keeps a sticky summary of every error it has reported. The summary is meant to be polled by software, or to drive a separate interrupt stage. A host reads the oldest character and its own flags at the head of the queue. A pop request removes that character.

The summary is accumulated in one of two modes. After any reset the block is in head mode. In this mode a character's flags join the summary only when the character becomes the head of the queue. A faulty character can therefore sit deeper in the queue without showing in the summary. A single command switches the block to entry mode, where flags join the summary at the moment the character is written. Entry mode is one-way: it stays set until a device reset or a receiver reset. A separate command clears the summary. A push that finds the queue full loses its character and raises the overrun flag.

Top module: `rxErrAccum`

## Requirements
- R1: After `rstN` is low, or after a cycle with `rxReset` high, the queue is empty, `errStatus` is 0 and `earlyMode` is 0. `rxReset` takes priority over every other input in its cycle.
- R2: Characters leave in the order they arrived. Up to DEPTH (16) characters are held. `headData` and `headErr` show the oldest entry whenever `empty` is 0. A pop while empty has no effect.
- R3: The error flag positions are bit 0 parity, bit 1 framing and bit 2 overrun. In head mode, at the clock edge where an entry becomes the head, its flags are ORed into `errStatus`. This covers a pop that exposes the next entry, a push into an empty queue, and a push with a pop on a one-entry queue.
- R4: In head mode, an entry with flags set that is not at the head leaves `errStatus` unchanged.
- R5: A command with code 5'b01101 sets `earlyMode` at the next edge. From then on, the flags of each accepted push are ORed into `errStatus` at that push's edge, and a new head adds nothing.
- R6: `earlyMode` stays 1 through any command or traffic. It returns to 0 only through `rstN` or `rxReset`.
- R7: `errStatus` bits only rise, except under the clear command 5'b01011. That command zeroes the status, while flags that become due in the same cycle still land.
- R8: A push while full with no pop is discarded. The queue contents stay the same and `errStatus` bit 2 is set at that edge, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous device reset, active low |
| rxReset | input | 1 | Synchronous receiver reset |
| pushValid | input | 1 | Write a character this cycle |
| pushData | input | 8 | Character to write |
| pushErr | input | 3 | Flags of that character (bit 0 parity, bit 1 framing, bit 2 overrun) |
| popReq | input | 1 | Remove the head entry |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 5 | Command opcode |
| headData | output | 8 | Character at the head |
| headErr | output | 3 | Flags of the head character |
| empty | output | 1 | Queue holds nothing |
| full | output | 1 | Queue holds DEPTH entries |
| errStatus | output | 3 | Sticky accumulated flags |
| earlyMode | output | 1 | Entry-mode accumulation active |

## Verification
The case hardest to reach from the ports is a faulty character buried behind clean ones in head mode. The summary must stay clear while that character advances, and must rise at exactly the pop that exposes it. A directed sequence fills the queue with one faulty entry in the middle, overfills the queue to force an overrun, and drains it while checking the summary at each step. Random traffic with rare clear, mode and receiver-reset commands then compares every output each cycle against a queue model in the bench. This traffic also covers push-with-pop on a one-entry queue and a clear that coincides with new flags.

// File: rtl/rxErrPkg.sv
package rxErrPkg;
  localparam int ERR_W = 3;
  localparam int ERR_PARITY = 0;
  localparam int ERR_FRAMING = 1;
  localparam int ERR_OVERRUN = 2;
  localparam logic [4:0] CMD_EARLY_ACC = 5'b01101;
  localparam logic [4:0] CMD_CLR_STATUS = 5'b01011;

  typedef struct packed {
    logic flush;
    logic wrEn;
    logic accPush;
    logic accNextHead;
    logic accHeadPush;
    logic setOverrun;
    logic clrStatus;
  } ctrlStrobeT;
endpackage

// File: rtl/rxErrCtrl.sv
module rxErrCtrl
  import rxErrPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxReset,
  input  logic             pushValid,
  input  logic             popReq,
  input  logic             cmdValid,
  input  logic [4:0]       cmdCode,
  output ctrlStrobeT       strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             empty,
  output logic             full,
  output logic             earlyMode
);
  logic [CNT_W-1:0] count;
  logic popOk, pushOk;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign popOk  = popReq & ~empty;
  assign pushOk = pushValid & (~full | popOk);

  always_comb begin
    strobe.flush       = rxReset;
    strobe.wrEn        = pushOk & ~rxReset;
    strobe.accPush     = earlyMode & pushOk;
    strobe.accNextHead = ~earlyMode & popOk & (count > CNT_W'(1));
    strobe.accHeadPush = ~earlyMode & pushOk &
                         (empty | (popOk & (count == CNT_W'(1))));
    strobe.setOverrun  = pushValid & ~pushOk;
    strobe.clrStatus   = cmdValid & (cmdCode == CMD_CLR_STATUS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      earlyMode <= 1'b0;
    end else if (rxReset) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      earlyMode <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= wrPtr + PTR_W'(1);
      if (popOk)  rdPtr <= rdPtr + PTR_W'(1);
      count <= count + CNT_W'(pushOk) - CNT_W'(popOk);
      if (cmdValid && cmdCode == CMD_EARLY_ACC) earlyMode <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R2
  AST_EARLY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (earlyMode && !rxReset) |=> earlyMode); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (full && pushValid && !popReq && !rxReset) |=> (full && $stable(wrPtr))); // R8
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !pushValid && !rxReset) |=> (empty && $stable(rdPtr))); // R2
  AST_RX_RESET: assert property (@(posedge clk) disable iff (!rstN)
    rxReset |=> (empty && !earlyMode)); // R1
endmodule

// File: rtl/rxErrData.sv
module rxErrData
  import rxErrPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int ENT_W = DATA_W + ERR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [DATA_W-1:0] pushData,
  input  logic [ERR_W-1:0]  pushErr,
  output logic [DATA_W-1:0] headData,
  output logic [ERR_W-1:0]  headErr,
  output logic [ERR_W-1:0]  errStatus
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] nextEntry;
  logic [ERR_W-1:0] newBits;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrPtr] <= {pushErr, pushData};
  end

  assign {headErr, headData} = mem[rdPtr];
  assign nextEntry = mem[rdPtr + PTR_W'(1)];

  always_comb begin
    newBits = '0;
    if (strobe.accPush)     newBits = newBits | pushErr;
    if (strobe.accHeadPush) newBits = newBits | pushErr;
    if (strobe.accNextHead) newBits = newBits | nextEntry[ENT_W-1 -: ERR_W];
    if (strobe.setOverrun)  newBits[ERR_OVERRUN] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errStatus <= '0;
    else if (strobe.flush) errStatus <= '0;
    else errStatus <= (strobe.clrStatus ? '0 : errStatus) | newBits;
  end

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrStatus && !strobe.flush) |=>
      ((errStatus & $past(errStatus)) == $past(errStatus))); // R7
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setOverrun && !strobe.flush) |=> errStatus[ERR_OVERRUN]); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.accPush, strobe.accHeadPush | strobe.accNextHead})); // R5
endmodule

// File: rtl/rxErrAccum.sv
module rxErrAccum
  import rxErrPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxReset,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic [2:0]        pushErr,
  input  logic              popReq,
  input  logic              cmdValid,
  input  logic [4:0]        cmdCode,
  output logic [DATA_W-1:0] headData,
  output logic [2:0]        headErr,
  output logic              empty,
  output logic              full,
  output logic [2:0]        errStatus,
  output logic              earlyMode
);
  ctrlStrobeT strobe;
  logic [PTR_W-1:0] wrPtr, rdPtr;

  rxErrCtrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .rxReset(rxReset), .pushValid(pushValid),
    .popReq(popReq), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .empty(empty), .full(full), .earlyMode(earlyMode)
  );

  rxErrData #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .pushData(pushData), .pushErr(pushErr), .headData(headData),
    .headErr(headErr), .errStatus(errStatus)
  );
endmodule

// File: tb/sim_rxErrAccum.sv
`timescale 1ns/1ps
module sim_rxErrAccum;
  localparam int DEPTH = 16;
  localparam logic [4:0] EARLY = 5'b01101;
  localparam logic [4:0] CLR = 5'b01011;

  logic clk = 0, rstN = 0, rxReset = 0, pushValid = 0, popReq = 0, cmdValid = 0;
  logic [7:0] pushData = 0;
  logic [2:0] pushErr = 0;
  logic [4:0] cmdCode = 0;
  logic [7:0] headData;
  logic [2:0] headErr, errStatus;
  logic empty, full, earlyMode;

  int nVec = 0, nFail = 0;
  logic [10:0] q[$];
  logic [2:0] mStatus = 0;
  bit mEarly = 0;

  always #10 clk = ~clk;

  rxErrAccum u0 (.*);

  task automatic chk(string tag, int act, int exp);
    nVec++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    chk({tag, " empty"}, int'(empty), int'(q.size() == 0));
    chk({tag, " full"}, int'(full), int'(q.size() == DEPTH));
    chk({tag, " status"}, int'(errStatus), int'(mStatus));
    chk({tag, " mode"}, int'(earlyMode), int'(mEarly));
    if (q.size() > 0) begin
      chk("R2 headData", int'(headData), int'(q[0][7:0]));
      chk("R2 headErr", int'(headErr), int'(q[0][10:8]));
    end
  endtask

  function automatic void modelStep(bit push, logic [7:0] d, logic [2:0] e,
                                    bit pop, bit cv, logic [4:0] cc, bit rr);
    int cnt = q.size();
    bit popOk, pushOk;
    logic [2:0] nb = 0;
    if (rr) begin
      q.delete(); mStatus = 0; mEarly = 0; return;
    end
    popOk = pop && cnt > 0;
    pushOk = push && (cnt < DEPTH || popOk);
    if (push && !pushOk) nb[2] = 1;
    if (mEarly && pushOk) nb |= e;
    if (!mEarly) begin
      if (popOk && cnt > 1) nb |= q[1][10:8];
      else if (pushOk && (cnt == 0 || (popOk && cnt == 1))) nb |= e;
    end
    mStatus = ((cv && cc == CLR) ? 3'b0 : mStatus) | nb;
    if (cv && cc == EARLY) mEarly = 1;
    if (popOk) void'(q.pop_front());
    if (pushOk) q.push_back({e, d});
  endfunction

  task automatic step(bit push, logic [7:0] d, logic [2:0] e, bit pop,
                      bit cv, logic [4:0] cc, bit rr, string tag);
    @(negedge clk);
    pushValid = push; pushData = d; pushErr = e; popReq = pop;
    cmdValid = cv; cmdCode = cc; rxReset = rr;
    @(posedge clk);
    modelStep(push, d, e, pop, cv, cc, rr);
    #5;
    compareAll(tag);
  endtask

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    #35 rstN = 1;
    #5 compareAll("R1 reset");

    // R4: fill with a parity-faulty entry at position 3
    for (int i = 0; i < DEPTH; i++)
      step(1, 8'(i + 8'h40), (i == 3) ? 3'b001 : 3'b000, 0, 0, 0, 0, "R4 fill");
    chk("R4 buried error hidden", int'(errStatus), 0);
    // R8: overfill
    step(1, 8'hEE, 3'b010, 0, 0, 0, 0, "R8 overfill");
    chk("R8 overrun set", int'(errStatus), 3'b100);
    chk("R8 head unchanged", int'(headData), 8'h40);
    // R7: clear
    step(0, 0, 0, 0, 1, CLR, 0, "R7 clear");
    chk("R7 cleared", int'(errStatus), 0);
    // R3: drain until faulty entry is head
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0, 0, "R3 drain");
    chk("R3 head error accumulated", int'(errStatus), 3'b001);
    // R5: early mode
    step(0, 0, 0, 0, 1, EARLY, 0, "R5 enter");
    step(0, 0, 0, 0, 1, CLR, 0, "R7 clear2");
    step(0, 0, 0, 1, 0, 0, 0, "R5 pop adds nothing");
    chk("R5 pop adds nothing", int'(errStatus), 0);
    step(1, 8'h99, 3'b010, 1, 0, 0, 0, "R5 push accumulates");
    chk("R5 push accumulates", int'(errStatus), 3'b010);
    // R6: hold, then receiver reset
    step(0, 0, 0, 0, 1, 5'b00000, 0, "R6 other cmd");
    chk("R6 mode held", int'(earlyMode), 1);
    step(0, 0, 0, 0, 0, 0, 1, "R1 rxReset");
    chk("R6 mode left by rxReset", int'(earlyMode), 0);
    // R3: push into empty, push+pop on single entry
    step(1, 8'h11, 3'b010, 0, 0, 0, 0, "R3 push empty");
    chk("R3 push into empty", int'(errStatus), 3'b010);
    step(1, 8'h12, 3'b001, 1, 0, 0, 0, "R3 push pop one");
    chk("R3 push+pop one entry", int'(errStatus), 3'b011);
    step(0, 0, 0, 0, 0, 0, 1, "R1 rxReset2");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit push = ($urandom % 100) < 55;
      bit pop = ($urandom % 100) < 45;
      logic [2:0] e = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
      int r = $urandom % 400;
      bit cv = r < 16;
      logic [4:0] cc = (r < 8) ? CLR : ((r < 10) ? EARLY : 5'($urandom));
      bit rr = (r == 399);
      step(push, 8'($urandom), e, pop, cv, cc, rr, "R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule